// File: doc/BRIEF.md
# Test Access Port Controller with Configuration Instruction Decoder

This block is the boundary-scan test access port for a small programmable device. It walks the sixteen-state TAP controller on the test clock and mode input. It holds an 8-bit instruction register. From the current opcode it picks which data register sits between the serial input and the serial output. Inside the block are a 1-bit bypass register, a 32-bit identification register, a 32-bit user code register and three configuration data registers of 12, 27 and 10 bits. Each configuration register has a shift stage and a held stage. The held values go out to a flash programming engine, which lives outside the block. The boundary register is external too. The block reaches it through a select line, capture/shift/update strobes and a serial return input.

The controller states are: Reset, Idle, DR-Select, DR-Capture, DR-Shift, DR-Exit1, DR-Pause, DR-Exit2, DR-Update, IR-Select, IR-Capture, IR-Shift, IR-Exit1, IR-Pause, IR-Exit2 and IR-Update. The transitions are listed below as the state followed by (next state with mode low / next state with mode high):

- Reset (Idle / Reset)
- Idle (Idle / DR-Select)
- DR-Select (DR-Capture / IR-Select)
- IR-Select (IR-Capture / Reset)
- either Capture (Shift / Exit1)
- either Shift (Shift / Exit1)
- either Exit1 (Pause / Update)
- either Pause (Pause / Exit2)
- either Exit2 (Shift / Update)
- either Update (Idle / DR-Select)

Shift and capture act on the rising test clock edge. Update stages and the serial output change on the falling edge. An active-low power-on reset puts the controller in Reset.

Top module: `tap_ctrl`

## Requirements
- R1: The state register follows the transition list above on each rising edge of `tck`. Five consecutive rising edges with `tms` high reach Reset from any state, and a path through DR-Pause and DR-Exit2 resumes shifting where it left off.
- R2: Power-on reset and the Reset state both make IDCODE (11111110) the current instruction. A data scan then returns 32'h29508093 least significant bit first. This value is version 0010, part 1001010100001000, maker 00001001001 and a final 1, written from the MSB down.
- R3: In IR-Capture the instruction shift stage loads 8'b00000001. Its three upper bits are 0 and its two lower bits are 01. This pattern appears at `tdo` LSB first during the IR shift.
- R4: The instruction shifts in LSB first on rising edges in IR-Shift and becomes current on the falling edge in IR-Update. The current instruction changes at no other time except Reset.
- R5: BYPASS (11111111), the configuration-load opcode (11110000), HIGHZ (11111100) and every opcode not named in R2, R5, R6, R7, R8, R9 or R10 select the 1-bit bypass register, which captures 0.
- R6: USERCODE (11111101) selects a 32-bit register that captures the `USERCODE` parameter.
- R7: The enable opcode (11101000) selects a 12-bit register. Capture loads its held value, and the falling edge in DR-Update copies the shift stage to `isc_enable_q`.
- R8: The erase (11101100), bulk (11101101), program (11101010) and verify (11101110) opcodes select the same 27-bit register. It behaves as in R7, with the held value on `isc_cfg_q`.
- R9: The incremental program (11101011) and incremental verify (11101111) opcodes select a 10-bit register. It behaves as in R7, with the held value on `isc_data_q`.
- R10: EXTEST (00000000), SAMPLE (00000001) and INTEST (00000010) raise `bnd_sel` and route `bnd_so` to `tdo`. They also gate the capture, shift and update strobes, which are each high in their DR state and never two at once.
- R11: `hiz_mode` is high exactly while HIGHZ is the current instruction.
- R12: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is high only while the controller is in IR-Shift or DR-Shift.
- R13: A held configuration value changes only in DR-Update with its own register selected. Scans under any other instruction leave all three held values untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, up to 10 MHz |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bnd_so | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data out, valid while `tdo_oe` is high |
| tdo_oe | output | 1 | Output enable for `tdo`; low means high impedance |
| bnd_sel | output | 1 | A boundary instruction is current |
| bnd_capture | output | 1 | Boundary capture strobe (DR-Capture) |
| bnd_shift | output | 1 | Boundary shift strobe (DR-Shift) |
| bnd_update | output | 1 | Boundary update strobe (DR-Update) |
| hiz_mode | output | 1 | All boundary outputs go high impedance |
| isc_enable_q | output | EN_W (12) | Held value of the enable register |
| isc_cfg_q | output | CFG_W (27) | Held value of the configuration register |
| isc_data_q | output | DAT_W (10) | Held value of the data register |

## Verification
The assertions assume `tms` and `tdi` move only while `tck` is low and settle well before the rising edge. They also assume power-on reset is released between edges. The five-edge rule relies on `tms` being high during reset, so past samples drawn from the reset period still describe a path that ends in Reset. The stimulus changes inputs two nanoseconds after each falling edge, holds `tms` high through reset, and releases reset mid-cycle. The external boundary register is modelled as a 4-bit chain that obeys the strobes, so the serial return stays well defined in every boundary scan.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 8;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SEL,
        ST_DR_CAP,
        ST_DR_SHIFT,
        ST_DR_EXIT1,
        ST_DR_PAUSE,
        ST_DR_EXIT2,
        ST_DR_UPD,
        ST_IR_SEL,
        ST_IR_CAP,
        ST_IR_SHIFT,
        ST_IR_EXIT1,
        ST_IR_PAUSE,
        ST_IR_EXIT2,
        ST_IR_UPD
    } tap_state_e;

    typedef enum logic [2:0] {
        DR_BYPASS,
        DR_IDENT,
        DR_USER,
        DR_BOUND,
        DR_ISC_EN,
        DR_ISC_CFG,
        DR_ISC_DAT
    } dr_sel_e;

    typedef struct packed {
        logic reset;
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
        logic cap_dr;
        logic sh_dr;
        logic upd_dr;
    } tap_ctl_t;

    localparam logic [IR_W-1:0] OP_EXTEST        = 8'b0000_0000;
    localparam logic [IR_W-1:0] OP_SAMPLE        = 8'b0000_0001;
    localparam logic [IR_W-1:0] OP_INTEST        = 8'b0000_0010;
    localparam logic [IR_W-1:0] OP_BYPASS        = 8'b1111_1111;
    localparam logic [IR_W-1:0] OP_IDCODE        = 8'b1111_1110;
    localparam logic [IR_W-1:0] OP_USERCODE      = 8'b1111_1101;
    localparam logic [IR_W-1:0] OP_HIGHZ         = 8'b1111_1100;
    localparam logic [IR_W-1:0] OP_CONF_LOAD     = 8'b1111_0000;
    localparam logic [IR_W-1:0] OP_CFG_ENABLE    = 8'b1110_1000;
    localparam logic [IR_W-1:0] OP_CFG_ERASE     = 8'b1110_1100;
    localparam logic [IR_W-1:0] OP_CFG_BULK      = 8'b1110_1101;
    localparam logic [IR_W-1:0] OP_CFG_PROG      = 8'b1110_1010;
    localparam logic [IR_W-1:0] OP_CFG_PROG_INC  = 8'b1110_1011;
    localparam logic [IR_W-1:0] OP_CFG_VERIFY    = 8'b1110_1110;
    localparam logic [IR_W-1:0] OP_CFG_VERIFY_INC = 8'b1110_1111;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_ctl_t   ctl
);

    tap_state_e state_nx;

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RESET:    state_nx = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_nx = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   state_nx = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   state_nx = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: state_nx = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: state_nx = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: state_nx = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: state_nx = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   state_nx = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   state_nx = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   state_nx = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: state_nx = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: state_nx = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: state_nx = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: state_nx = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   state_nx = tms ? ST_DR_SEL   : ST_IDLE;
            default:     state_nx = ST_RESET;
        endcase
    end

    // state register
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) state <= ST_RESET;
        else        state <= state_nx;
    end

    // per-state control outputs
    always_comb begin
        ctl = '0;
        unique case (state)
            ST_RESET:    ctl.reset  = 1'b1;
            ST_IR_CAP:   ctl.cap_ir = 1'b1;
            ST_IR_SHIFT: ctl.sh_ir  = 1'b1;
            ST_IR_UPD:   ctl.upd_ir = 1'b1;
            ST_DR_CAP:   ctl.cap_dr = 1'b1;
            ST_DR_SHIFT: ctl.sh_dr  = 1'b1;
            ST_DR_UPD:   ctl.upd_dr = 1'b1;
            default:     ctl = '0;
        endcase
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
#(
    parameter logic [IR_W-1:0] CAPTURE = 8'b0000_0001
) (
    input  logic            tck,
    input  logic            por_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap,
    input  logic            sh,
    input  logic            upd,
    output logic [IR_W-1:0] ir_sr,
    output logic [IR_W-1:0] ir_q,
    output dr_sel_e         dr_sel,
    output logic            hiz
);

    // shift stage: rising edge
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)   ir_sr <= CAPTURE;
        else if (cap) ir_sr <= CAPTURE;
        else if (sh)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // current instruction: falling edge
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n)        ir_q <= OP_IDCODE;
        else if (in_reset) ir_q <= OP_IDCODE;
        else if (upd)      ir_q <= ir_sr;
    end

    // opcode decode
    always_comb begin
        hiz = 1'b0;
        case (ir_q)
            OP_EXTEST, OP_SAMPLE, OP_INTEST:           dr_sel = DR_BOUND;
            OP_IDCODE:                                 dr_sel = DR_IDENT;
            OP_USERCODE:                               dr_sel = DR_USER;
            OP_CFG_ENABLE:                             dr_sel = DR_ISC_EN;
            OP_CFG_ERASE, OP_CFG_BULK,
            OP_CFG_PROG, OP_CFG_VERIFY:                dr_sel = DR_ISC_CFG;
            OP_CFG_PROG_INC, OP_CFG_VERIFY_INC:        dr_sel = DR_ISC_DAT;
            OP_HIGHZ: begin
                dr_sel = DR_BYPASS;
                hiz    = 1'b1;
            end
            default:                                   dr_sel = DR_BYPASS;
        endcase
    end

endmodule

// File: rtl/tap_isc_reg.sv
module tap_isc_reg #(
    parameter int W = 12
) (
    input  logic         tck,
    input  logic         por_n,
    input  logic         tdi,
    input  logic         sel,
    input  logic         cap,
    input  logic         sh,
    input  logic         upd,
    output logic         so,
    output logic [W-1:0] held
);

    logic [W-1:0] sr;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)          sr <= '0;
        else if (sel && cap) sr <= held;
        else if (sel && sh)  sr <= {tdi, sr[W-1:1]};
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n)          held <= '0;
        else if (sel && upd) held <= sr;
    end

    assign so = sr[0];

endmodule

// File: rtl/tap_dr_bank.sv
module tap_dr_bank
    import tap_pkg::*;
#(
    parameter logic [31:0] IDCODE   = 32'h2950_8093,
    parameter logic [31:0] USERCODE = 32'h3C5A_96E1,
    parameter int          EN_W     = 12,
    parameter int          CFG_W    = 27,
    parameter int          DAT_W    = 10,
    localparam int         ISC_TOT  = EN_W + CFG_W + DAT_W
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tdi,
    input  logic               cap,
    input  logic               sh,
    input  logic               upd,
    input  dr_sel_e            dr_sel,
    output logic               dr_so,
    output logic [ISC_TOT-1:0] isc_flat
);

    logic        byp_q;
    logic [31:0] id_sr;
    logic [31:0] user_sr;
    logic [2:0]  isc_so;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            byp_q   <= 1'b0;
            id_sr   <= IDCODE;
            user_sr <= USERCODE;
        end else begin
            if (dr_sel == DR_BYPASS) begin
                if (cap)     byp_q <= 1'b0;
                else if (sh) byp_q <= tdi;
            end
            if (dr_sel == DR_IDENT) begin
                if (cap)     id_sr <= IDCODE;
                else if (sh) id_sr <= {tdi, id_sr[31:1]};
            end
            if (dr_sel == DR_USER) begin
                if (cap)     user_sr <= USERCODE;
                else if (sh) user_sr <= {tdi, user_sr[31:1]};
            end
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_isc
        localparam int      W_G   = (g == 0) ? EN_W : (g == 1) ? CFG_W : DAT_W;
        localparam int      OFF_G = (g == 0) ? 0 : (g == 1) ? EN_W : EN_W + CFG_W;
        localparam dr_sel_e SEL_G = (g == 0) ? DR_ISC_EN : (g == 1) ? DR_ISC_CFG : DR_ISC_DAT;

        tap_isc_reg #(.W(W_G)) u_reg (
            .tck  (tck),
            .por_n(por_n),
            .tdi  (tdi),
            .sel  (dr_sel == SEL_G),
            .cap  (cap),
            .sh   (sh),
            .upd  (upd),
            .so   (isc_so[g]),
            .held (isc_flat[OFF_G +: W_G])
        );
    end

    always_comb begin
        case (dr_sel)
            DR_BYPASS:  dr_so = byp_q;
            DR_IDENT:   dr_so = id_sr[0];
            DR_USER:    dr_so = user_sr[0];
            DR_ISC_EN:  dr_so = isc_so[0];
            DR_ISC_CFG: dr_so = isc_so[1];
            DR_ISC_DAT: dr_so = isc_so[2];
            default:    dr_so = 1'b0;
        endcase
    end

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import tap_pkg::*;
#(
    parameter logic [31:0] IDCODE   = 32'h2950_8093,
    parameter logic [31:0] USERCODE = 32'h3C5A_96E1,
    parameter int          EN_W     = 12,
    parameter int          CFG_W    = 27,
    parameter int          DAT_W    = 10
) (
    input  logic             tck,
    input  logic             por_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic             bnd_so,
    output logic             tdo,
    output logic             tdo_oe,
    output logic             bnd_sel,
    output logic             bnd_capture,
    output logic             bnd_shift,
    output logic             bnd_update,
    output logic             hiz_mode,
    output logic [EN_W-1:0]  isc_enable_q,
    output logic [CFG_W-1:0] isc_cfg_q,
    output logic [DAT_W-1:0] isc_data_q
);

    localparam int ISC_TOT = EN_W + CFG_W + DAT_W;

    tap_state_e         state;
    tap_ctl_t           ctl;
    logic [IR_W-1:0]    ir_sr;
    logic [IR_W-1:0]    ir_q;
    dr_sel_e            dr_sel;
    logic               dr_so;
    logic               so_mux;
    logic [ISC_TOT-1:0] isc_flat;

    tap_fsm u_fsm (
        .tck  (tck),
        .por_n(por_n),
        .tms  (tms),
        .state(state),
        .ctl  (ctl)
    );

    tap_ir u_ir (
        .tck     (tck),
        .por_n   (por_n),
        .tdi     (tdi),
        .in_reset(ctl.reset),
        .cap     (ctl.cap_ir),
        .sh      (ctl.sh_ir),
        .upd     (ctl.upd_ir),
        .ir_sr   (ir_sr),
        .ir_q    (ir_q),
        .dr_sel  (dr_sel),
        .hiz     (hiz_mode)
    );

    tap_dr_bank #(
        .IDCODE  (IDCODE),
        .USERCODE(USERCODE),
        .EN_W    (EN_W),
        .CFG_W   (CFG_W),
        .DAT_W   (DAT_W)
    ) u_bank (
        .tck     (tck),
        .por_n   (por_n),
        .tdi     (tdi),
        .cap     (ctl.cap_dr),
        .sh      (ctl.sh_dr),
        .upd     (ctl.upd_dr),
        .dr_sel  (dr_sel),
        .dr_so   (dr_so),
        .isc_flat(isc_flat)
    );

    assign bnd_sel     = (dr_sel == DR_BOUND);
    assign bnd_capture = bnd_sel & ctl.cap_dr;
    assign bnd_shift   = bnd_sel & ctl.sh_dr;
    assign bnd_update  = bnd_sel & ctl.upd_dr;

    assign isc_enable_q = isc_flat[EN_W-1:0];
    assign isc_cfg_q    = isc_flat[EN_W +: CFG_W];
    assign isc_data_q   = isc_flat[EN_W+CFG_W +: DAT_W];

    always_comb begin
        if (ctl.sh_ir)    so_mux = ir_sr[0];
        else if (bnd_sel) so_mux = bnd_so;
        else              so_mux = dr_so;
    end

    // serial output stage on the falling edge
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= so_mux;
            tdo_oe <= ctl.sh_ir | ctl.sh_dr;
        end
    end

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
    import tap_pkg::*;
#(
    parameter int ISC_W = 49
) (
    input logic             tck,
    input logic             por_n,
    input logic             tms,
    input tap_state_e       state,
    input logic [IR_W-1:0]  ir_sr,
    input logic [IR_W-1:0]  ir_q,
    input logic             tdo_oe,
    input logic             bnd_capture,
    input logic             bnd_shift,
    input logic             bnd_update,
    input logic             hiz_mode,
    input logic [ISC_W-1:0] isc_held
);

    // R1
    five_high_reset_chk: assert property (@(posedge tck) disable iff (!por_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state == ST_RESET));

    // R3
    ir_capture_pattern_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_IR_CAP) |=> (ir_sr[1:0] == 2'b01 && ir_sr[IR_W-1:IR_W-3] == 3'b000));

    // R4
    ir_change_window_chk: assert property (@(posedge tck) disable iff (!por_n)
        !$stable(ir_q) |-> (state == ST_IR_UPD || state == ST_RESET));

    // R10
    bnd_strobe_excl_chk: assert property (@(posedge tck) disable iff (!por_n)
        $onehot0({bnd_capture, bnd_shift, bnd_update}));

    // R11
    hiz_entry_chk: assert property (@(posedge tck) disable iff (!por_n)
        $rose(hiz_mode) |-> (state == ST_IR_UPD));

    // R12
    tdo_enable_chk: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe == (state == ST_IR_SHIFT || state == ST_DR_SHIFT));

    // R13
    isc_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
        !$stable(isc_held) |-> (state == ST_DR_UPD));

endmodule

bind tap_ctrl tap_ctrl_chk #(.ISC_W(ISC_TOT)) chk_i (
    .tck        (tck),
    .por_n      (por_n),
    .tms        (tms),
    .state      (state),
    .ir_sr      (ir_sr),
    .ir_q       (ir_q),
    .tdo_oe     (tdo_oe),
    .bnd_capture(bnd_capture),
    .bnd_shift  (bnd_shift),
    .bnd_update (bnd_update),
    .hiz_mode   (hiz_mode),
    .isc_held   (isc_flat)
);

// File: tb/tap_ctrl_tb_top.sv
`timescale 1ns/1ps
module tap_ctrl_tb_top;

    localparam logic [31:0] ID_V   = 32'h2950_8093;
    localparam logic [31:0] USER_V = 32'h3C5A_96E1;

    typedef struct {
        logic  b;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done     = 0;

    logic        tck = 0;
    logic        por_n, tms, tdi;
    logic        bnd_so;
    logic        tdo, tdo_oe, bnd_sel, bnd_capture, bnd_shift, bnd_update, hiz_mode;
    logic [11:0] isc_enable_q;
    logic [26:0] isc_cfg_q;
    logic [9:0]  isc_data_q;
    logic [3:0]  bmod = 4'b0;
    int          upd_cnt = 0;

    always #10 tck = ~tck;

    tap_ctrl dut_i (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .bnd_so(bnd_so),
        .tdo(tdo), .tdo_oe(tdo_oe), .bnd_sel(bnd_sel), .bnd_capture(bnd_capture),
        .bnd_shift(bnd_shift), .bnd_update(bnd_update), .hiz_mode(hiz_mode),
        .isc_enable_q(isc_enable_q), .isc_cfg_q(isc_cfg_q), .isc_data_q(isc_data_q)
    );

    // external 4-bit boundary chain model
    always @(posedge tck) begin
        if (bnd_capture)    bmod <= 4'b1010;
        else if (bnd_shift) bmod <= {tdi, bmod[3:1]};
        if (bnd_update)     upd_cnt <= upd_cnt + 1;
    end
    assign bnd_so = bmod[0];

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: one expected bit per enabled falling edge
    initial begin
        forever begin
            @(negedge tck);
            #1;
            if (tdo_oe === 1'b1) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_errors++;
                    $display("FAIL R12 unexpected shift bit act=%b exp=none", tdo);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (tdo !== e.b) begin
                        n_errors++;
                        $display("FAIL %s tdo act=%b exp=%b", e.req, tdo, e.b);
                    end
                end
            end
        end
    end

    function automatic logic [63:0] exp_scan(int w, logic [63:0] cap, logic [63:0] din);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            if (i < w) r[i] = cap[i];
            else       r[i] = din[i-w];
        end
        return r;
    endfunction

    task automatic push_bits(int n, logic [63:0] v, string req);
        for (int i = 0; i < n; i++) exp_q.push_back('{v[i], req});
    endtask

    task automatic step(logic m, logic d);
        @(negedge tck);
        #2;
        tms = m;
        tdi = d;
    endtask

    task automatic load_ir(logic [7:0] op);
        push_bits(8, 64'h01, "R3");
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 8; i++) step(i == 7, op[i]);
        step(1, 0); step(0, 0);
        step(0, 0);
    endtask

    task automatic scan_dr(int n, logic [63:0] din, logic [63:0] exp, string req);
        push_bits(n, exp, req);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
        step(1, 0); step(0, 0);
        step(0, 0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int c0;
        por_n = 0; tms = 1; tdi = 0;
        #55;
        por_n = 1;
        #10;
        check(tdo_oe == 0, "R12 reset oe", 64'(tdo_oe), 0);
        check(hiz_mode == 0 && bnd_sel == 0, "R2 reset decode", {hiz_mode, bnd_sel}, 0);
        check(isc_enable_q == 0 && isc_cfg_q == 0 && isc_data_q == 0, "R7 reset held",
              64'(isc_cfg_q), 0);
        step(0, 0);
        step(0, 0);

        // R2 identification after power-on
        scan_dr(32, 64'h0123_4567_89AB_CDEF, exp_scan(32, 64'(ID_V), 64'h0123_4567_89AB_CDEF), "R2");
        check(tdo_oe == 0, "R12 idle oe", 64'(tdo_oe), 0);

        // R6 user code with overshift
        load_ir(8'b1111_1101);
        scan_dr(40, 64'h00_5555_AAAA_F00F, exp_scan(32, 64'(USER_V), 64'h00_5555_AAAA_F00F), "R6");

        // R5 bypass variants
        load_ir(8'b1111_1111);
        scan_dr(8, 64'hB4, exp_scan(1, 0, 64'hB4), "R5 bypass");
        load_ir(8'h5A);
        scan_dr(8, 64'h6D, exp_scan(1, 0, 64'h6D), "R5 unlisted");
        load_ir(8'b1111_0000);
        check(hiz_mode == 0, "R11 conf-load no hiz", 64'(hiz_mode), 0);
        scan_dr(6, 64'h2B, exp_scan(1, 0, 64'h2B), "R5 conf-load");
        load_ir(8'b1111_1100);
        check(hiz_mode == 1, "R11 highz", 64'(hiz_mode), 1);
        scan_dr(6, 64'h19, exp_scan(1, 0, 64'h19), "R5 highz");

        // R10 boundary routing
        c0 = upd_cnt;
        load_ir(8'b0000_0001);
        check(bnd_sel == 1 && hiz_mode == 0, "R10 sample sel", {bnd_sel, hiz_mode}, 2);
        scan_dr(8, 64'hC3, exp_scan(4, 64'hA, 64'hC3), "R10 sample");
        check(upd_cnt == c0 + 1, "R10 update strobe", 64'(upd_cnt - c0), 1);
        load_ir(8'b0000_0000);
        check(bnd_sel == 1, "R10 extest sel", 64'(bnd_sel), 1);
        load_ir(8'b0000_0010);
        check(bnd_sel == 1, "R10 intest sel", 64'(bnd_sel), 1);

        // R7 enable register
        load_ir(8'b1110_1000);
        check(bnd_sel == 0, "R10 isc not bound", 64'(bnd_sel), 0);
        scan_dr(12, 64'hA5C, exp_scan(12, 0, 64'hA5C), "R7");
        check(isc_enable_q == 12'hA5C, "R7 held", 64'(isc_enable_q), 64'hA5C);
        scan_dr(16, 64'h3E71, exp_scan(12, 64'hA5C, 64'h3E71), "R7 len");
        check(isc_enable_q == 12'h3E7, "R7 held2", 64'(isc_enable_q), 64'h3E7);

        // R13 other instruction leaves held values
        load_ir(8'b1111_1111);
        scan_dr(8, 64'hFF, exp_scan(1, 0, 64'hFF), "R5");
        check(isc_enable_q == 12'h3E7, "R13 enable kept", 64'(isc_enable_q), 64'h3E7);

        // R8 configuration register via four opcodes
        load_ir(8'b1110_1100);
        scan_dr(27, 64'h4D2_B3C1, exp_scan(27, 0, 64'h4D2_B3C1), "R8 erase");
        check(isc_cfg_q == 27'h4D2_B3C1, "R8 held", 64'(isc_cfg_q), 64'h4D2_B3C1);
        load_ir(8'b1110_1110);
        scan_dr(30, 64'h2345_6789, exp_scan(27, 64'h4D2_B3C1, 64'h2345_6789), "R8 verify");
        check(isc_cfg_q == 27'(64'h2345_6789 >> 3), "R8 held2", 64'(isc_cfg_q), 64'h2345_6789 >> 3);
        load_ir(8'b1110_1101);
        scan_dr(27, 0, exp_scan(27, 64'h2345_6789 >> 3, 0), "R8 bulk");
        load_ir(8'b1110_1010);
        scan_dr(27, 64'h12, exp_scan(27, 0, 64'h12), "R8 program");

        // R9 data register
        load_ir(8'b1110_1011);
        scan_dr(10, 64'h2C9, exp_scan(10, 0, 64'h2C9), "R9 prog-inc");
        check(isc_data_q == 10'h2C9, "R9 held", 64'(isc_data_q), 64'h2C9);
        load_ir(8'b1110_1111);
        scan_dr(10, 64'h136, exp_scan(10, 64'h2C9, 64'h136), "R9 verify-inc");
        check(isc_data_q == 10'h136, "R9 held2", 64'(isc_data_q), 64'h136);
        check(isc_cfg_q == 27'h12 && isc_enable_q == 12'h3E7, "R13 others kept",
              64'(isc_cfg_q), 64'h12);

        // R2 / R1 reset through five high tms edges
        load_ir(8'b1111_1100);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        step(0, 0);
        check(hiz_mode == 0, "R2 reset clears highz", 64'(hiz_mode), 0);
        scan_dr(32, 0, exp_scan(32, 64'(ID_V), 0), "R1 R2 after reset");

        // R1 pause path splits one identification scan
        push_bits(32, 64'(ID_V), "R1 pause");
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 16; i++) step(i == 15, 0);
        step(0, 0); step(0, 0);
        check(tdo_oe == 0, "R12 pause oe", 64'(tdo_oe), 0);
        step(1, 0); step(0, 0);
        for (int i = 0; i < 16; i++) step(i == 15, 0);
        step(1, 0); step(0, 0);
        step(0, 0);
        check(tdo_oe == 0, "R12 idle oe end", 64'(tdo_oe), 0);

        step(0, 0);
        check(exp_q.size() == 0, "R12 all bits seen", 64'(exp_q.size()), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule